// File: doc/BRIEF.md
# Edge-Capturing GPIO Group with Split Interrupt Banks

This block controls one group of 32 general-purpose pins on behalf of a processor that reaches it through a small synchronous register bus. For each pin, software chooses whether the pin is an input or an output. Output levels are changed only through a write-one-to-set command word and a write-one-to-clear command word. A single store therefore changes chosen pins without a read-modify-write sequence.

Every pin level passes through a synchronizer chain into the local clock domain, and software can read it back at any time. Rising and falling transitions have their own per-pin enables, and each enable also has its own set and clear command words. An enabled transition latches a sticky status bit, which software clears by writing a one to it. The status vector is cut into two 16-pin halves. Each half drives its own interrupt line, and each line is gated by one bit of a bank-enable register.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the direction word reads all ones, the output drive and all output enables are zero, the edge enables, status and bank-enable word read zero, and both interrupt lines are low.
- R2: A direction bit of 1 makes its pin an input (`gpio_oe` bit 0). A 0 makes it an output (`gpio_oe` bit 1). The direction word (address 0x0) is read/write and reads back what was written.
- R3: Writing address 0x1 sets the output bits written as 1, and writing address 0x2 clears them. Bits written as 0 keep their value, and both addresses read back the current output word. The output word changes only through these two addresses.
- R4: Address 0x3 returns the synchronized pin levels, whatever the pin's direction. A pin change first shows there after the second rising clock edge, so an earlier read still returns the old level. Writes to 0x3 have no effect.
- R5: The rising-edge enable word is set through address 0x4 and cleared through 0x5, and both addresses read it back. A low-to-high transition on a pin whose rising enable is 1 sets its status bit at the third clock edge after the pin changes. Without that enable, the transition sets nothing.
- R6: The falling-edge enable word is set through address 0x6 and cleared through 0x7, and both addresses read it back. A high-to-low transition on an enabled pin latches its status bit. With both enables set, either transition direction latches it.
- R7: The status word (address 0x8) holds each latched bit until a write to 0x8 with a 1 in that position clears it. Bits written as 0 are untouched.
- R8: When a new enabled transition and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R9: `irq[0]` is high exactly when bank-enable bit 0 (address 0x9) is 1 and any of status bits 15:0 is set. `irq[1]` does the same for bank-enable bit 1 and status bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| gpio_in | input | 32 | Pin levels from the pads |
| gpio_out | output | 32 | Output drive levels |
| gpio_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 2 | Per-bank interrupt lines |

## Verification
The checker assumes that `wr_en`, `addr` and `wr_data` are stable around each rising clock edge. It also assumes that `gpio_in` is held at zero through reset, so the synchronizer starts at the level the pads present and no transition is seen at release. The bench drives the bus and the pins only on falling edges, holds the pins low while reset is asserted, and changes a pin only after the previous change has finished passing through the synchronizer. Each edge-detection check therefore lines up with a known clock edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int REG_ADDR_W = 4;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_DIR      = 4'h0,
      REG_OUT_SET  = 4'h1,
      REG_OUT_CLR  = 4'h2,
      REG_PIN_IN   = 4'h3,
      REG_RISE_SET = 4'h4,
      REG_RISE_CLR = 4'h5,
      REG_FALL_SET = 4'h6,
      REG_FALL_CLR = 4'h7,
      REG_EVT_STAT = 4'h8,
      REG_BANK_EN  = 4'h9
   } reg_sel_e;

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] hist_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= stage_q[STAGES-1];
   end

   assign q      = stage_q[STAGES-1];
   assign q_prev = hist_q;

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int               WIDTH     = 32,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= RESET_VAL;
      else if (set_we) q <= q | mask;
      else if (clr_we) q <= q & ~mask;
   end

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] level_prev,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] stat
);

   logic [WIDTH-1:0] rise_hit;
   logic [WIDTH-1:0] fall_hit;
   logic [WIDTH-1:0] drop;

   always_comb begin
      rise_hit = level & ~level_prev & rise_en;
      fall_hit = ~level & level_prev & fall_en;
      drop     = clr_we ? clr_mask : '0;
   end

   // new events are ORed in after the clear, so they win on a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~drop) | rise_hit | fall_hit;
   end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
   parameter int NUM_PINS = 32,
   parameter int BANK_W   = 16,
   parameter bit IRQ_REG  = 1'b0,
   localparam int NUM_BANKS = NUM_PINS / BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  stat,
   input  logic [NUM_BANKS-1:0] bank_en,
   output logic [NUM_BANKS-1:0] irq
);

   logic [NUM_BANKS-1:0] pend;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign pend[b] = bank_en[b] & (|stat[b*BANK_W +: BANK_W]);
      end

      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= '0;
            else        irq <= pend;
         end
      end else begin : g_comb
         assign irq = pend;
      end
   endgenerate

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int BANK_W      = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0,
   localparam int NUM_BANKS  = NUM_PINS / BANK_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [NUM_PINS-1:0]   gpio_in,
   output logic [NUM_PINS-1:0]   gpio_out,
   output logic [NUM_PINS-1:0]   gpio_oe,
   output logic [NUM_BANKS-1:0]  irq
);

   generate
      if (NUM_PINS % BANK_W != 0) begin : g_chk_bank
         $error("NUM_PINS must be a whole number of banks");
      end
      if (NUM_PINS > DATA_W) begin : g_chk_width
         $error("NUM_PINS must fit in the data word");
      end
      if (NUM_BANKS > DATA_W) begin : g_chk_banks
         $error("bank enables must fit in the data word");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("at least two synchronizer stages are required");
      end
   endgenerate

   logic [NUM_PINS-1:0]  dir_q;
   logic [NUM_PINS-1:0]  out_q;
   logic [NUM_PINS-1:0]  rise_en_q;
   logic [NUM_PINS-1:0]  fall_en_q;
   logic [NUM_PINS-1:0]  evt_stat_q;
   logic [NUM_BANKS-1:0] bank_en_q;
   logic [NUM_PINS-1:0]  pin_lvl;
   logic [NUM_PINS-1:0]  pin_lvl_prev;
   logic [NUM_PINS-1:0]  wmask;

   logic we_dir, we_out_set, we_out_clr, we_rise_set, we_rise_clr;
   logic we_fall_set, we_fall_clr, we_stat, we_ben;

   assign wmask = wr_data[NUM_PINS-1:0];

   always_comb begin
      we_dir      = wr_en && (addr == REG_DIR);
      we_out_set  = wr_en && (addr == REG_OUT_SET);
      we_out_clr  = wr_en && (addr == REG_OUT_CLR);
      we_rise_set = wr_en && (addr == REG_RISE_SET);
      we_rise_clr = wr_en && (addr == REG_RISE_CLR);
      we_fall_set = wr_en && (addr == REG_FALL_SET);
      we_fall_clr = wr_en && (addr == REG_FALL_CLR);
      we_stat     = wr_en && (addr == REG_EVT_STAT);
      we_ben      = wr_en && (addr == REG_BANK_EN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '1;
      else if (we_dir) dir_q <= wmask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank_en_q <= '0;
      else if (we_ben) bank_en_q <= wr_data[NUM_BANKS-1:0];
   end

   gpio_setclr_reg #(.WIDTH(NUM_PINS), .RESET_VAL('0)) u_out_reg (
      .clk(clk), .rst_n(rst_n),
      .set_we(we_out_set), .clr_we(we_out_clr), .mask(wmask), .q(out_q)
   );

   gpio_setclr_reg #(.WIDTH(NUM_PINS), .RESET_VAL('0)) u_rise_reg (
      .clk(clk), .rst_n(rst_n),
      .set_we(we_rise_set), .clr_we(we_rise_clr), .mask(wmask), .q(rise_en_q)
   );

   gpio_setclr_reg #(.WIDTH(NUM_PINS), .RESET_VAL('0)) u_fall_reg (
      .clk(clk), .rst_n(rst_n),
      .set_we(we_fall_set), .clr_we(we_fall_clr), .mask(wmask), .q(fall_en_q)
   );

   gpio_sync_chain #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pin_lvl), .q_prev(pin_lvl_prev)
   );

   gpio_evt_status #(.WIDTH(NUM_PINS)) u_status (
      .clk(clk), .rst_n(rst_n),
      .level(pin_lvl), .level_prev(pin_lvl_prev),
      .rise_en(rise_en_q), .fall_en(fall_en_q),
      .clr_we(we_stat), .clr_mask(wmask), .stat(evt_stat_q)
   );

   gpio_bank_irq #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat(evt_stat_q), .bank_en(bank_en_q), .irq(irq)
   );

   always_comb begin
      unique case (addr)
         REG_DIR:                   rd_data = DATA_W'(dir_q);
         REG_OUT_SET, REG_OUT_CLR:  rd_data = DATA_W'(out_q);
         REG_PIN_IN:                rd_data = DATA_W'(pin_lvl);
         REG_RISE_SET, REG_RISE_CLR: rd_data = DATA_W'(rise_en_q);
         REG_FALL_SET, REG_FALL_CLR: rd_data = DATA_W'(fall_en_q);
         REG_EVT_STAT:              rd_data = DATA_W'(evt_stat_q);
         REG_BANK_EN:               rd_data = DATA_W'(bank_en_q);
         default:                   rd_data = '0;
      endcase
   end

   assign gpio_out = out_q;
   assign gpio_oe  = ~dir_q;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
   import gpio_edge_pkg::*;
#(
   parameter int NUM_PINS   = 32,
   parameter int BANK_W     = 16,
   parameter int DATA_W     = 32,
   parameter bit IRQ_REG    = 1'b0,
   localparam int NUM_BANKS = NUM_PINS / BANK_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [REG_ADDR_W-1:0] addr,
   input logic [DATA_W-1:0]     wr_data,
   input logic [NUM_PINS-1:0]   gpio_out,
   input logic [NUM_PINS-1:0]   gpio_oe,
   input logic [NUM_BANKS-1:0]  irq,
   input logic [NUM_PINS-1:0]   stat,
   input logic [NUM_BANKS-1:0]  ben
);

   logic [NUM_PINS-1:0] wm;
   assign wm = wr_data[NUM_PINS-1:0];

   AST_DIR_WRITE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DIR) |=> (gpio_oe == ~$past(wm)));  // R2

   AST_OUT_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_OUT_SET) |=> (gpio_out == ($past(gpio_out) | $past(wm))));  // R3

   AST_OUT_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_OUT_CLR) |=> (gpio_out == ($past(gpio_out) & ~$past(wm))));  // R3

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (addr == REG_OUT_SET || addr == REG_OUT_CLR)) |=> $stable(gpio_out));  // R3

   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == REG_EVT_STAT) |=> ((stat & $past(stat)) == $past(stat)));  // R7

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         if (IRQ_REG) begin : g_reg
            AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
               irq[b] |-> ($past(ben[b]) && (|$past(stat[b*BANK_W +: BANK_W]))));  // R9
         end else begin : g_comb
            AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
               irq[b] |-> (ben[b] && (|stat[b*BANK_W +: BANK_W])));  // R9
            AST_IRQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
               (ben[b] && (|stat[b*BANK_W +: BANK_W])) |-> irq[b]);  // R9
         end
      end
   endgenerate

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
   .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .DATA_W(DATA_W), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq),
   .stat(evt_stat_q), .ben(bank_en_q)
);

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] gpio_in = '0;
   logic [31:0] gpio_out;
   logic [31:0] gpio_oe;
   logic [1:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_edge_bank u_gpio_edge_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .gpio_in(gpio_in), .gpio_out(gpio_out),
      .gpio_oe(gpio_oe), .irq(irq)
   );

   // vector: {write, addr, data (write value or expected read), requirement}
   localparam logic [44:0] VEC [NVEC] = '{
      {1'b0, 4'h0, 32'hFFFF_FFFF, 8'd1},  // R1 direction all inputs
      {1'b0, 4'h1, 32'h0000_0000, 8'd1},  // R1 output zero
      {1'b0, 4'h8, 32'h0000_0000, 8'd1},  // R1 status zero
      {1'b0, 4'h9, 32'h0000_0000, 8'd1},  // R1 bank enables zero
      {1'b1, 4'h0, 32'h0000_FFFF, 8'd2},  // R2
      {1'b0, 4'h0, 32'h0000_FFFF, 8'd2},  // R2 readback
      {1'b1, 4'h1, 32'h0000_00F0, 8'd3},  // R3
      {1'b1, 4'h1, 32'h0000_0F00, 8'd3},  // R3
      {1'b0, 4'h2, 32'h0000_0FF0, 8'd3},  // R3 read via clear address
      {1'b1, 4'h2, 32'h0000_0030, 8'd3},  // R3
      {1'b0, 4'h1, 32'h0000_0FC0, 8'd3},  // R3
      {1'b1, 4'h4, 32'h0000_0001, 8'd5},  // R5
      {1'b1, 4'h6, 32'h0001_0000, 8'd6},  // R6
      {1'b1, 4'h4, 32'h0001_0000, 8'd6},  // R6 both enables on pin 16
      {1'b0, 4'h5, 32'h0001_0001, 8'd5},  // R5
      {1'b1, 4'h5, 32'h0000_0001, 8'd5},  // R5
      {1'b0, 4'h4, 32'h0001_0000, 8'd5},  // R5
      {1'b0, 4'h7, 32'h0001_0000, 8'd6},  // R6
      {1'b1, 4'h3, 32'hFFFF_FFFF, 8'd4},  // R4 write ignored
      {1'b0, 4'h3, 32'h0000_0000, 8'd4}   // R4
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // called just after a falling edge; consumes no clock
   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   // called just after a falling edge; returns at the next falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic negs(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 oe", gpio_oe, 32'h0);
      check("R1 out", gpio_out, 32'h0);
      check("R1 irq", {30'd0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v][44]) wr(VEC[v][43:40], VEC[v][39:8]);
         else            rd(VEC[v][43:40], VEC[v][39:8], $sformatf("R%0d vec%0d", VEC[v][7:0], v));
      end
      check("R2 oe", gpio_oe, 32'hFFFF_0000);
      check("R3 out", gpio_out, 32'h0000_0FC0);

      // R4: two-edge lag on the pin readback
      gpio_in = 32'h0000_00FF;
      negs(1); rd(4'h3, 32'h0000_0000, "R4 old level");
      negs(1); rd(4'h3, 32'h0000_00FF, "R4 new level");
      negs(1); rd(4'h8, 32'h0, "R5 rise disabled");

      // R6: falling without fall enable latches nothing
      wr(4'h4, 32'h0000_0001);
      gpio_in = 32'h0000_00FE;
      negs(3); rd(4'h8, 32'h0, "R6 fall disabled");

      // R5: rising on enabled pin 0, third edge
      gpio_in = 32'h0000_00FF;
      negs(2); rd(4'h8, 32'h0, "R5 before third edge");
      negs(1); rd(4'h8, 32'h0000_0001, "R5 latched");
      check("R9 bank off", {30'd0, irq}, 32'h0);
      wr(4'h9, 32'h1);
      check("R9 bank0 on", {30'd0, irq}, 32'h1);

      // R6: pin 16 both enables, rising then falling
      gpio_in = 32'h0001_00FF;
      negs(3); rd(4'h8, 32'h0001_0001, "R6 rise on pin16");
      check("R9 bank1 off", {30'd0, irq}, 32'h1);
      wr(4'h9, 32'h3);
      check("R9 both", {30'd0, irq}, 32'h3);
      wr(4'h8, 32'h0001_0000);
      rd(4'h8, 32'h0000_0001, "R7 selective clear");
      check("R9 bank1 cleared", {30'd0, irq}, 32'h1);
      gpio_in = 32'h0000_00FF;
      negs(3); rd(4'h8, 32'h0001_0001, "R6 fall on pin16");
      wr(4'h9, 32'h2);
      check("R9 bank0 gated", {30'd0, irq}, 32'h2);
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, 32'h0, "R7 clear all");
      check("R9 none", {30'd0, irq}, 32'h0);

      // R8: event and clear collide on pin 16
      gpio_in = 32'h0001_00FF;
      negs(2);
      wr(4'h8, 32'h0001_0000);
      rd(4'h8, 32'h0001_0000, "R8 event wins");
      wr(4'h8, 32'h0001_0000);
      rd(4'h8, 32'h0, "R7 later clear");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule